// File: doc/BRIEF.md
# Edge-Stepped Digital Phase Aligner

This controller holds the phase position of an output clock as a tap index within one output period. Each rising edge of an asynchronous step strobe moves that position by one step. A lead/lag level, sampled at the same edge, sets the direction. The phase word can drive a downstream interpolator or tap selector.

The number of steps in one output period depends on a 2-bit post-divider select. When the select changes, the position is rescaled so that the fraction of a period it represents is kept. Updates are dropped on a fixed count of strobe edges.

There are two ways to use the block:
- **Phase alignment.** Feed a reference clock to the strobe and a feedback clock to the lead/lag input.
- **Fixed delay.** Tie lead/lag to a constant and apply a counted burst of strobe edges.

Top module: `phase_step_aligner`

## Requirements
- R1: While `rst` is high on a clock edge, `phaseWord` becomes 0 and the dropped-edge count restarts. After reset, the first dropped edge is the 32nd strobe edge.
- R2: Each rising edge of `strobeAsync` moves `phaseWord` by exactly one step. The change is visible after the third rising `clk` edge after the strobe goes high. A strobe held high produces only one step.
- R3: Lead/lag is sampled through the same two-stage synchronizer, in the cycle the edge is detected. High (1) advances: `phaseWord` decreases by one. Low (0) delays: `phaseWord` increases by one.
- R4: Steps per output period (N) by `postDivSel`:
  - 2'b11 gives 768.
  - 2'b10 gives 1536.
  - 2'b01 gives 3072.
  - 2'b00 is treated as 2'b11 (768).
- R5: The position wraps modulo N. Advancing from 0 gives N-1, and delaying from N-1 gives 0. `phaseWord` never reaches N.
- R6: Strobe edges are counted in groups of 32, and the 32nd edge of every group changes nothing.
- R7: A change of N rescales the position on the next clock edge.
  - Going to a finer N multiplies the position by the ratio.
  - Going to a coarser N divides it by the ratio and drops the fraction (floor).
- R8: A strobe edge detected in the same cycle as a select change is discarded, and the rescale alone takes effect. That edge still counts toward the group of 32.
- R9: With lead/lag held low, K strobe edges from reset give `phaseWord` = K - floor(K/32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobeAsync | input | 1 | Step strobe, asynchronous; each rising edge requests one step |
| leadLagAsync | input | 1 | Direction level, asynchronous: 1 advance, 0 delay |
| postDivSel | input | 2 | Post-divider select that sets the steps per period |
| phaseWord | output | PW (12) | Phase position in steps, 0 to N-1 |

## Verification
The bench builds the block with its default parameters:
- a base of 768 steps;
- a drop every 32 edges;
- two synchronizer stages.

With these values, every wrap point is reachable in a handful of edges. The first dropped edge comes within tens of strobes, and a 200-edge fixed-delay burst shows six dropped updates in under two thousand cycles. The default synchronizer depth fixes the three-cycle latency that the timing check measures. The two-bit select reaches all three rescaling ratios.

// File: rtl/phal_pkg.sv
package phal_pkg;

  typedef logic [1:0] shift_t;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic   stepEn;     // apply one step this cycle
    logic   advance;    // 1: decrement position, 0: increment
    logic   rescale;    // resolution change this cycle
    shift_t fromShift;  // resolution currently held
    shift_t toShift;    // resolution requested by the select
  } strb_t;

  // Finer resolution is a larger left shift of the base step count
  function automatic shift_t selToShift(input logic [1:0] sel);
    case (sel)
      2'b10:   return 2'd1;
      2'b01:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/phal_ctrl.sv
module phal_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int SKIP_EVERY  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobeAsync,
  input  logic            leadLagAsync,
  input  logic [1:0]      postDivSel,
  output phal_pkg::strb_t strb
);
  import phal_pkg::*;

  localparam int CW  = $clog2(SKIP_EVERY);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0]  strobeSync;
  logic [TOP:0]  leadSync;
  logic          strobeLast;
  logic [CW-1:0] skipCnt;
  shift_t        heldShift;
  shift_t        wantShift;
  logic          edgeSeen;
  logic          skipHit;
  logic          rescaleNeed;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) begin
            strobeSync[0] <= 1'b0;
            leadSync[0]   <= 1'b0;
          end else begin
            strobeSync[0] <= strobeAsync;
            leadSync[0]   <= leadLagAsync;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (rst) begin
            strobeSync[g] <= 1'b0;
            leadSync[g]   <= 1'b0;
          end else begin
            strobeSync[g] <= strobeSync[g-1];
            leadSync[g]   <= leadSync[g-1];
          end
        end
      end
    end
  endgenerate

  assign wantShift   = selToShift(postDivSel);
  assign edgeSeen    = strobeSync[TOP] & ~strobeLast;
  assign skipHit     = (skipCnt == CW'(SKIP_EVERY - 1));
  assign rescaleNeed = (wantShift != heldShift);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobeLast <= 1'b0;
      skipCnt    <= '0;
      heldShift  <= '0;
    end else begin
      strobeLast <= strobeSync[TOP];
      heldShift  <= wantShift;
      if (edgeSeen) skipCnt <= skipHit ? '0 : skipCnt + 1'b1;
    end
  end

  always_comb begin
    strb.stepEn    = edgeSeen & ~skipHit & ~rescaleNeed;
    strb.advance   = leadSync[TOP];
    strb.rescale   = rescaleNeed;
    strb.fromShift = heldShift;
    strb.toShift   = wantShift;
  end

endmodule

// File: rtl/phal_dpath.sv
module phal_dpath #(
  parameter int BASE_STEPS = 768,
  parameter int PW         = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  phal_pkg::strb_t strb,
  output logic [PW-1:0]   phaseWord
);
  logic [PW-1:0] modulus;
  logic [PW-1:0] lastTap;
  logic [PW-1:0] nextPos;

  assign modulus = PW'(BASE_STEPS) << strb.fromShift;
  assign lastTap = modulus - 1'b1;

  always_comb begin
    nextPos = phaseWord;
    if (strb.rescale) begin
      if (strb.toShift > strb.fromShift)
        nextPos = phaseWord << (strb.toShift - strb.fromShift);
      else
        nextPos = phaseWord >> (strb.fromShift - strb.toShift);
    end else if (strb.stepEn) begin
      if (strb.advance)
        nextPos = (phaseWord == '0) ? lastTap : phaseWord - 1'b1;
      else
        nextPos = (phaseWord == lastTap) ? '0 : phaseWord + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phaseWord <= '0;
    else     phaseWord <= nextPos;
  end

endmodule

// File: rtl/phase_step_aligner.sv
module phase_step_aligner #(
  parameter  int BASE_STEPS  = 768,
  parameter  int SKIP_EVERY  = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int PW          = $clog2(BASE_STEPS * 4)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobeAsync,
  input  logic          leadLagAsync,
  input  logic [1:0]    postDivSel,
  output logic [PW-1:0] phaseWord
);
  phal_pkg::strb_t ctrlStrb;

  phal_ctrl #(.SYNC_STAGES(SYNC_STAGES), .SKIP_EVERY(SKIP_EVERY)) u_ctrl (
    .clk(clk), .rst(rst), .strobeAsync(strobeAsync),
    .leadLagAsync(leadLagAsync), .postDivSel(postDivSel), .strb(ctrlStrb)
  );

  phal_dpath #(.BASE_STEPS(BASE_STEPS), .PW(PW)) u_dpath (
    .clk(clk), .rst(rst), .strb(ctrlStrb), .phaseWord(phaseWord)
  );

endmodule

// File: rtl/phal_chk.sv
module phal_chk #(
  parameter int BASE_STEPS = 768,
  parameter int PW         = 12
) (
  input logic            clk,
  input logic            rst,
  input logic [PW-1:0]   phaseWord,
  input phal_pkg::strb_t strb
);
  logic [PW-1:0] modulus;
  assign modulus = PW'(BASE_STEPS) << strb.fromShift;

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    phaseWord < modulus); // R5

  AST_ONE_STEP_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
    strb.stepEn |=> !strb.stepEn); // R2

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
    (strb.stepEn && !strb.rescale) |=> !$stable(phaseWord)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!strb.stepEn && !strb.rescale) |=> $stable(phaseWord)); // R6

  AST_ADVANCE_DEC: assert property (@(posedge clk) disable iff (rst)
    (strb.stepEn && strb.advance && phaseWord != '0)
      |=> phaseWord == $past(phaseWord) - 1'b1); // R3

  AST_DELAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strb.stepEn && !strb.advance && phaseWord == modulus - 1'b1)
      |=> phaseWord == '0); // R5

endmodule

bind phase_step_aligner phal_chk #(.BASE_STEPS(BASE_STEPS), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .phaseWord(phaseWord), .strb(ctrlStrb)
);

// File: tb/test_phase_step_aligner.sv
module test_phase_step_aligner;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic        leadLag = 1'b0;
  logic [1:0]  sel = 2'b11;
  logic [11:0] phaseWord;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit rateWin = 1'b0;
  int stRise = 0;
  int llRise = 0;

  always #4 clk = ~clk; // 125 MHz

  phase_step_aligner i_phase_step_aligner (
    .clk(clk), .rst(rst), .strobeAsync(strobe), .leadLagAsync(leadLag),
    .postDivSel(sel), .phaseWord(phaseWord)
  );

  // Vector table: select, lead/lag level, edge count from reset, expected word
  localparam int NV = 8;
  localparam logic [1:0] VSEL [NV] = '{2'b11, 2'b11, 2'b10, 2'b01, 2'b11, 2'b11, 2'b11, 2'b01};
  localparam bit         VADV [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam int         VCNT [NV] = '{5, 1, 3, 2, 32, 64, 33, 40};
  localparam int         VEXP [NV] = '{5, 767, 1533, 3070, 31, 62, 736, 39};
  localparam string      VREQ [NV] = '{"R3", "R5", "R4", "R4", "R6", "R6", "R5", "R9"};

  always @(posedge strobe)  if (rateWin) stRise++;
  always @(posedge leadLag) if (rateWin) llRise++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] s, input logic ll);
    @(negedge clk);
    sel = s; leadLag = ll; strobe = 1'b0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      strobe = 1'b1;
      repeat (3) @(negedge clk);
      strobe = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    doReset(2'b11, 1'b0);
    check("R1 reset", phaseWord, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      doReset(VSEL[v], VADV[v]);
      pulses(VCNT[v]);
      check(VREQ[v], phaseWord, VEXP[v]);
    end

    // R2: latency and held-high strobe
    doReset(2'b11, 1'b0);
    strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R2 before third edge", phaseWord, 0);
    @(posedge clk); @(negedge clk);
    check("R2 after third edge", phaseWord, 1);
    repeat (10) @(negedge clk);
    check("R2 held high", phaseWord, 1);
    strobe = 1'b0;
    repeat (4) @(negedge clk);

    // R1: reset mid-run restarts drop count
    pulses(20);
    doReset(2'b11, 1'b0);
    check("R1 cleared", phaseWord, 0);
    pulses(32);
    check("R1 skip restarts", phaseWord, 31);

    // R7: rescaling
    doReset(2'b11, 1'b0);
    pulses(10);
    sel = 2'b10; repeat (3) @(negedge clk);
    check("R7 to 1536", phaseWord, 20);
    sel = 2'b01; repeat (3) @(negedge clk);
    check("R7 to 3072", phaseWord, 40);
    pulses(3);
    sel = 2'b11; repeat (3) @(negedge clk);
    check("R7 floor to 768", phaseWord, 10);
    sel = 2'b00; repeat (3) @(negedge clk);
    check("R4 sel 00 same as 11", phaseWord, 10);

    // R8: edge coinciding with a select change
    doReset(2'b11, 1'b0);
    pulses(10);
    strobe = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    sel = 2'b10;
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 step discarded", phaseWord, 20);
    pulses(21);
    check("R8 edge still counted", phaseWord, 40);

    // R9: fixed-delay burst
    doReset(2'b11, 1'b0);
    pulses(200);
    check("R9 200 edges", phaseWord, 194);

    // R3: phase-align pattern with lead/lag toggling as a clock
    doReset(2'b11, 1'b0);
    rateWin = 1'b1;
    for (int i = 0; i < 10; i++) begin
      leadLag = 1'b1; strobe = 1'b1;
      repeat (4) @(negedge clk);
      leadLag = 1'b0; strobe = 1'b0;
      repeat (4) @(negedge clk);
    end
    rateWin = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 align advance", phaseWord, 758);
    // stimulus rule: strobe edge rate must not exceed lead/lag toggle rate
    check("R3 stimulus rate", (stRise <= llRise) ? 1 : 0, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule